// File: doc/BRIEF.md
# Memory Test Pattern Sequencer

This block drives a memory under test with address and data streams that it computes as it goes, so no vector storage is needed. Software-free operation is assumed: a single `start` pulse latches the configuration (algorithm, index of the last word to visit, and data polarity) and the sequencer then issues one memory operation per cycle until the selected algorithm completes. Three algorithm families are available: a solid pass pair, a checkerboard pass pair, and a four-element march.

Internally the sequencer walks a physical linear index whose low bits are the column coordinate x and whose high bits are the row coordinate y. Column moves fastest, so consecutive operations touch horizontal neighbours and a row change moves one row down. Each physical (y, x) pair is turned into an external device address by a scrambling stage that mirrors the lower row bits and lower column bits depending on the top bit of each coordinate.

For every read the sequencer presents the expected word. The returned word is compared one cycle later; the first mismatch latches its device address and sets a sticky error flag that stays until the next accepted start.

Top module: `mem_pattern_gen`

## Requirements
- R1: After reset `busy`, `done`, `errFlag`, `memWe` and `memRe` are 0 and `failAddr` is 0.
- R2: The physical index p has x = p[COL_BITS-1:0] and y = p[ADDR_W-1:COL_BITS]. The device address is {y_top, x_top, x_low XOR replicated NOT x_top, y_low XOR replicated y_top}, where _top is the coordinate's MSB and _low the remaining bits; with 4 row and 3 column bits index 0 maps to 24 and index 127 maps to 120.
- R3: With `cfgAlgo` = 0 (solid) the block writes indices 0..T in ascending order and then reads 0..T ascending; the word for index p is p's low DATA_W bits (zero-extended) XOR the replicated `cfgInvert` bit.
- R4: With `cfgAlgo` = 1 (checkerboard) the pass order is as in R3 and every bit of the word equals x[0] XOR y[0] XOR `cfgInvert`.
- R5: With `cfgAlgo` = 2 or 3 (march) and background B = replicated `cfgInvert`, the operations are: ascending write B; ascending read B then write NOT B per word; descending read NOT B then write B per word; ascending read B.
- R6: While `busy` exactly one of `memWe`/`memRe` is 1 each cycle; while not busy both are 0.
- R7: `memRdData` is compared with the expected word in the cycle after the read; the first mismatch sets `errFlag` and loads `failAddr` with that read's device address; later mismatches change neither.
- R8: An accepted start clears `errFlag` and `failAddr`; `done` rises one cycle after the last operation, when the final compare has been taken, and holds until the next accepted start.
- R9: While `busy`, `start` and all configuration inputs are ignored.
- R10: `cfgTopIndex` = T selects T+1 words, including T = 0 (a single word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle or done |
| cfgAlgo | input | 2 | 0 solid, 1 checkerboard, 2/3 march |
| cfgTopIndex | input | ROW_BITS+COL_BITS | Last physical index visited |
| cfgInvert | input | 1 | Data polarity |
| memRdData | input | DATA_W | Word returned by the memory one cycle after a read |
| memAddr | output | ROW_BITS+COL_BITS | Scrambled device address |
| memWrData | output | DATA_W | Write word |
| memWe | output | 1 | Write strobe |
| memRe | output | 1 | Read strobe |
| memExpData | output | DATA_W | Expected word for the current read |
| busy | output | 1 | Operations are being issued |
| done | output | 1 | Run finished, verdict final |
| errFlag | output | 1 | Sticky mismatch flag |
| failAddr | output | ROW_BITS+COL_BITS | Device address of the first mismatch |

## Verification
The assertions watch, on every cycle, that reads and writes never coincide and stop outside a run, that the error flag and fail address never change between starts once set, that an error can only appear two cycles after a read, and that `done` holds and never overlaps `busy`. The exact address order, the scrambling map, the data pattern of each algorithm, the descending march element, the run length for small and single-word ranges, and the immunity to configuration changes mid-run can only be shown by the bench's scenarios, which replay each run against a behavioural operation list and an injected read fault.

// File: rtl/mtpg_pkg.sv
package mtpg_pkg;

  typedef enum logic [1:0] {
    ALG_SOLID     = 2'd0,
    ALG_CHECK     = 2'd1,
    ALG_MARCH     = 2'd2,
    ALG_MARCH_ALT = 2'd3
  } algo_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch configuration
    logic clrErr;    // clear verdict registers
    logic idxZero;   // load index 0
    logic idxTop;    // load last index
    logic stepUp;
    logic stepDown;
    logic doWr;
    logic doRd;
    logic flipData;  // use complement of background
  } ctrlStrobe_t;

  // one march element or pass
  typedef struct packed {
    logic firstRd;    // first operation is a read
    logic twoOps;     // read followed by write on each word
    logic descending;
    logic inv0;       // complement for first operation
    logic inv1;       // complement for second operation
  } elemDesc_t;

  function automatic logic isMarch(algo_e algo);
    return (algo == ALG_MARCH) || (algo == ALG_MARCH_ALT);
  endfunction

  function automatic logic [1:0] lastElem(algo_e algo);
    return isMarch(algo) ? 2'd3 : 2'd1;
  endfunction

  function automatic elemDesc_t elemDesc(algo_e algo, logic [1:0] elem);
    elemDesc_t d;
    d = '0;
    if (isMarch(algo)) begin
      case (elem)
        2'd0: d = '0;
        2'd1: begin d.firstRd = 1'b1; d.twoOps = 1'b1; d.inv1 = 1'b1; end
        2'd2: begin d.firstRd = 1'b1; d.twoOps = 1'b1; d.descending = 1'b1; d.inv0 = 1'b1; end
        default: d.firstRd = 1'b1;
      endcase
    end else begin
      d.firstRd = (elem != 2'd0);
    end
    return d;
  endfunction

endpackage

// File: rtl/mtpg_scramble.sv
module mtpg_scramble #(
  parameter int ROW_BITS = 9,
  parameter int COL_BITS = 8
) (
  input  logic [ROW_BITS-1:0]          rowPhys,
  input  logic [COL_BITS-1:0]          colPhys,
  output logic [ROW_BITS+COL_BITS-1:0] devAddr
);
  logic                rowTop;
  logic                colTop;
  logic [ROW_BITS-2:0] rowLow;
  logic [COL_BITS-2:0] colLow;

  assign rowTop = rowPhys[ROW_BITS-1];
  assign colTop = colPhys[COL_BITS-1];
  // lower half of the row range is mirrored when the top row bit is set
  assign rowLow = rowPhys[ROW_BITS-2:0] ^ {(ROW_BITS-1){rowTop}};
  // lower half of the column range is mirrored when the top column bit is clear
  assign colLow = colPhys[COL_BITS-2:0] ^ {(COL_BITS-1){~colTop}};

  assign devAddr = {rowTop, colTop, colLow, rowLow};
endmodule

// File: rtl/mtpg_control.sv
module mtpg_control
  import mtpg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [1:0]  cfgAlgo,
  input  logic        idxAtTop,
  input  logic        idxAtZero,
  output ctrlStrobe_t strobe,
  output algo_e       algoQ,
  output logic        busy,
  output logic        done
);
  seqState_e state, stateN;
  algo_e     algoN;
  logic [1:0] elem, elemN;
  logic       opSel, opSelN;
  elemDesc_t  curDesc, nextDesc;
  logic       atBound;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      algoQ <= ALG_SOLID;
      elem  <= 2'd0;
      opSel <= 1'b0;
    end else begin
      state <= stateN;
      algoQ <= algoN;
      elem  <= elemN;
      opSel <= opSelN;
    end
  end

  always_comb begin
    strobe   = '0;
    stateN   = state;
    algoN    = algoQ;
    elemN    = elem;
    opSelN   = opSel;
    curDesc  = elemDesc(algoQ, elem);
    nextDesc = elemDesc(algoQ, elem + 2'd1);
    atBound  = curDesc.descending ? idxAtZero : idxAtTop;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strobe.capture = 1'b1;
          strobe.clrErr  = 1'b1;
          strobe.idxZero = 1'b1;
          algoN          = algo_e'(cfgAlgo);
          elemN          = 2'd0;
          opSelN         = 1'b0;
          stateN         = ST_RUN;
        end
      end
      ST_RUN: begin
        strobe.doRd     = opSel ? 1'b0 : curDesc.firstRd;
        strobe.doWr     = opSel ? 1'b1 : ~curDesc.firstRd;
        strobe.flipData = opSel ? curDesc.inv1 : curDesc.inv0;
        if (curDesc.twoOps && !opSel) begin
          opSelN = 1'b1;
        end else begin
          opSelN = 1'b0;
          if (atBound) begin
            if (elem == lastElem(algoQ)) begin
              stateN = ST_FLUSH;
            end else begin
              elemN = elem + 2'd1;
              if (nextDesc.descending) strobe.idxTop = 1'b1;
              else                     strobe.idxZero = 1'b1;
            end
          end else if (curDesc.descending) begin
            strobe.stepDown = 1'b1;
          end else begin
            strobe.stepUp = 1'b1;
          end
        end
      end
      default: stateN = ST_DONE;  // flush: final compare taken this cycle
    endcase
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/mtpg_datapath.sv
module mtpg_datapath
  import mtpg_pkg::*;
#(
  parameter int ROW_BITS = 9,
  parameter int COL_BITS = 8,
  parameter int DATA_W   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  algo_e                         algo,
  input  logic [ROW_BITS+COL_BITS-1:0]  cfgTopIndex,
  input  logic                          cfgInvert,
  input  logic [DATA_W-1:0]             memRdData,
  output logic [ROW_BITS+COL_BITS-1:0]  memAddr,
  output logic [DATA_W-1:0]             memWrData,
  output logic [DATA_W-1:0]             memExpData,
  output logic                          memWe,
  output logic                          memRe,
  output logic                          idxAtTop,
  output logic                          idxAtZero,
  output logic                          errFlag,
  output logic [ROW_BITS+COL_BITS-1:0]  failAddr
);
  localparam int ADDR_W = ROW_BITS + COL_BITS;

  logic [ADDR_W-1:0]   idx, topQ, devAddr, rdAddrQ;
  logic                polQ, rdPendQ;
  logic [ROW_BITS-1:0] rowPhys;
  logic [COL_BITS-1:0] colPhys;
  logic [DATA_W-1:0]   solidWord, baseWord, cellWord, rdExpQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx  <= '0;
      topQ <= '0;
      polQ <= 1'b0;
    end else begin
      if (strobe.capture) begin
        topQ <= cfgTopIndex;
        polQ <= cfgInvert;
      end
      if (strobe.idxZero)       idx <= '0;
      else if (strobe.idxTop)   idx <= topQ;
      else if (strobe.stepUp)   idx <= idx + 1'b1;
      else if (strobe.stepDown) idx <= idx - 1'b1;
    end
  end

  assign idxAtTop  = (idx == topQ);
  assign idxAtZero = (idx == '0);

  // x runs fastest: low index bits are the column
  assign colPhys = idx[COL_BITS-1:0];
  assign rowPhys = idx[ADDR_W-1:COL_BITS];

  mtpg_scramble #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) scr_i (
    .rowPhys (rowPhys),
    .colPhys (colPhys),
    .devAddr (devAddr)
  );

  // solid word: low index bits, zero-extended when the word is wider
  for (genvar b = 0; b < DATA_W; b++) begin : g_solid
    if (b < ADDR_W) begin : g_bit
      assign solidWord[b] = idx[b];
    end else begin : g_pad
      assign solidWord[b] = 1'b0;
    end
  end

  always_comb begin
    case (algo)
      ALG_SOLID: baseWord = solidWord;
      ALG_CHECK: baseWord = {DATA_W{colPhys[0] ^ rowPhys[0]}};
      default:   baseWord = '0;
    endcase
  end

  assign cellWord   = baseWord ^ {DATA_W{polQ ^ strobe.flipData}};
  assign memAddr    = devAddr;
  assign memWrData  = cellWord;
  assign memExpData = cellWord;
  assign memWe      = strobe.doWr;
  assign memRe      = strobe.doRd;

  // read-return compare, one cycle behind the read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPendQ  <= 1'b0;
      rdExpQ   <= '0;
      rdAddrQ  <= '0;
      errFlag  <= 1'b0;
      failAddr <= '0;
    end else begin
      rdPendQ <= strobe.doRd;
      if (strobe.doRd) begin
        rdExpQ  <= cellWord;
        rdAddrQ <= devAddr;
      end
      if (strobe.clrErr) begin
        errFlag  <= 1'b0;
        failAddr <= '0;
      end else if (rdPendQ && (memRdData != rdExpQ) && !errFlag) begin
        errFlag  <= 1'b1;
        failAddr <= rdAddrQ;
      end
    end
  end
endmodule

// File: rtl/mem_pattern_gen.sv
module mem_pattern_gen
  import mtpg_pkg::*;
#(
  parameter int ROW_BITS = 9,
  parameter int COL_BITS = 8,
  parameter int DATA_W   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [1:0]                    cfgAlgo,
  input  logic [ROW_BITS+COL_BITS-1:0]  cfgTopIndex,
  input  logic                          cfgInvert,
  input  logic [DATA_W-1:0]             memRdData,
  output logic [ROW_BITS+COL_BITS-1:0]  memAddr,
  output logic [DATA_W-1:0]             memWrData,
  output logic                          memWe,
  output logic                          memRe,
  output logic [DATA_W-1:0]             memExpData,
  output logic                          busy,
  output logic                          done,
  output logic                          errFlag,
  output logic [ROW_BITS+COL_BITS-1:0]  failAddr
);
  ctrlStrobe_t strobe;
  algo_e       algoQ;
  logic        idxAtTop, idxAtZero;

  mtpg_control ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .cfgAlgo   (cfgAlgo),
    .idxAtTop  (idxAtTop),
    .idxAtZero (idxAtZero),
    .strobe    (strobe),
    .algoQ     (algoQ),
    .busy      (busy),
    .done      (done)
  );

  mtpg_datapath #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .algo        (algoQ),
    .cfgTopIndex (cfgTopIndex),
    .cfgInvert   (cfgInvert),
    .memRdData   (memRdData),
    .memAddr     (memAddr),
    .memWrData   (memWrData),
    .memExpData  (memExpData),
    .memWe       (memWe),
    .memRe       (memRe),
    .idxAtTop    (idxAtTop),
    .idxAtZero   (idxAtZero),
    .errFlag     (errFlag),
    .failAddr    (failAddr)
  );
endmodule

// File: rtl/mem_pattern_gen_checker.sv
module mem_pattern_gen_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              memWe,
  input logic              memRe,
  input logic              busy,
  input logic              done,
  input logic              errFlag,
  input logic [ADDR_W-1:0] failAddr
);
  p_excl_ops_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  p_quiet_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memWe && !memRe));

  p_one_op_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (memWe || memRe));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !start) |=> errFlag);

  p_fail_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !start) |=> $stable(failAddr));

  p_err_after_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(memRe, 2));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));
endmodule

bind mem_pattern_gen mem_pattern_gen_checker #(.ADDR_W(ROW_BITS + COL_BITS)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .memWe    (memWe),
  .memRe    (memRe),
  .busy     (busy),
  .done     (done),
  .errFlag  (errFlag),
  .failAddr (failAddr)
);

// File: tb/mem_pattern_gen_tb.sv
module mem_pattern_gen_tb_top;
  localparam int RB = 4;
  localparam int CB = 3;
  localparam int DW = 4;
  localparam int AW = RB + CB;
  localparam int NW = 1 << AW;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } refOp_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    cfgAlgo = 2'd0;
  logic [AW-1:0] cfgTopIndex = '0;
  logic          cfgInvert = 1'b0;
  logic [DW-1:0] memRdData = '0;
  logic [AW-1:0] memAddr, failAddr;
  logic [DW-1:0] memWrData, memExpData;
  logic          memWe, memRe, busy, done, errFlag;

  int checks = 0;
  int failures = 0;
  refOp_t expQ[$];
  logic [DW-1:0] mem [0:NW-1];
  logic [DW-1:0] refMem [0:NW-1];
  logic [AW-1:0] faultAddr = '0;
  logic [DW-1:0] faultMask = '0;
  logic          expErr;
  logic [AW-1:0] expFail;
  logic          monOn = 1'b0;
  logic          seenBusy = 1'b0;
  logic [AW-1:0] firstAddr = '0, lastAddr = '0;
  string         dataReq = "R3";

  always #10 clk = ~clk;

  mem_pattern_gen #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cfgAlgo(cfgAlgo),
    .cfgTopIndex(cfgTopIndex), .cfgInvert(cfgInvert), .memRdData(memRdData),
    .memAddr(memAddr), .memWrData(memWrData), .memWe(memWe), .memRe(memRe),
    .memExpData(memExpData), .busy(busy), .done(done), .errFlag(errFlag),
    .failAddr(failAddr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural address map: mirror low halves by coordinate top bits
  function automatic int devAddrOf(int p);
    int y, x, yTop, xTop, yLow, xLow, ym, xm;
    ym = (1 << (RB - 1)) - 1;
    xm = (1 << (CB - 1)) - 1;
    y = p / (1 << CB);
    x = p % (1 << CB);
    yTop = y / (1 << (RB - 1));
    xTop = x / (1 << (CB - 1));
    yLow = y % (1 << (RB - 1));
    xLow = x % (1 << (CB - 1));
    if (yTop == 1) yLow = ym - yLow;
    if (xTop == 0) xLow = xm - xLow;
    return yTop * (1 << (AW - 1)) + xTop * (1 << (AW - 2)) + xLow * (1 << (RB - 1)) + yLow;
  endfunction

  function automatic logic [DW-1:0] patternOf(int algo, int p, bit pol);
    logic [DW-1:0] ones = '1;
    logic [DW-1:0] w;
    if (algo == 0) w = DW'(p % (1 << DW));
    else if (algo == 1) w = (((p % 2) + ((p / (1 << CB)) % 2)) % 2 == 1) ? ones : '0;
    else w = '0;
    return pol ? ~w : w;
  endfunction

  task automatic addOp(bit we, int p, logic [DW-1:0] d);
    refOp_t o;
    logic [AW-1:0] a;
    a = AW'(devAddrOf(p));
    o.we = we; o.addr = a; o.data = d;
    expQ.push_back(o);
    if (we) refMem[a] = d;
    else if (!expErr && ((refMem[a] ^ ((a == faultAddr) ? faultMask : '0)) != d)) begin
      expErr = 1'b1;
      expFail = a;
    end
  endtask

  task automatic buildOps(int algo, int top, bit pol);
    logic [DW-1:0] bg;
    expErr = 1'b0;
    expFail = '0;
    for (int i = 0; i < NW; i++) refMem[i] = '0;
    bg = pol ? '1 : '0;
    if (algo < 2) begin
      for (int p = 0; p <= top; p++) addOp(1'b1, p, patternOf(algo, p, pol));
      for (int p = 0; p <= top; p++) addOp(1'b0, p, patternOf(algo, p, pol));
    end else begin
      for (int p = 0; p <= top; p++) addOp(1'b1, p, bg);
      for (int p = 0; p <= top; p++) begin addOp(1'b0, p, bg); addOp(1'b1, p, ~bg); end
      for (int p = top; p >= 0; p--) begin addOp(1'b0, p, ~bg); addOp(1'b1, p, bg); end
      for (int p = 0; p <= top; p++) addOp(1'b0, p, bg);
    end
  endtask

  // memory model with an injected read fault
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWrData;
    if (memRe) memRdData <= mem[memAddr] ^ ((memAddr == faultAddr) ? faultMask : '0);
  end

  // per-cycle comparison against the reference operation list
  always @(negedge clk) begin
    if (monOn) begin
      if (busy) begin
        if (!seenBusy) firstAddr <= memAddr;
        seenBusy <= 1'b1;
        lastAddr <= memAddr;
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "extra operation", 1, 0);
        end else begin
          refOp_t o;
          o = expQ.pop_front();
          check(memWe == o.we && memRe == !o.we, "R6", "op kind (we)", memWe, o.we);
          check(memAddr == o.addr, "R2", "address", memAddr, o.addr);
          if (o.we) check(memWrData == o.data, dataReq, "write data", memWrData, o.data);
          else      check(memExpData == o.data, dataReq, "expected data", memExpData, o.data);
        end
      end else begin
        check(!memWe && !memRe, "R6", "strobe while idle", {memWe, memRe}, 0);
      end
    end
  end

  task automatic runTest(int algo, int top, bit pol, int faultIdx, logic [DW-1:0] mask,
                         bit disturb, string req);
    dataReq = req;
    faultAddr = (faultIdx >= 0) ? AW'(devAddrOf(faultIdx)) : '0;
    faultMask = (faultIdx >= 0) ? mask : '0;
    buildOps(algo, top, pol);
    @(posedge clk); #2;
    seenBusy = 1'b0;
    start = 1'b1; cfgAlgo = 2'(algo); cfgTopIndex = AW'(top); cfgInvert = pol;
    @(posedge clk); #2;
    start = 1'b0;
    check(!errFlag && failAddr == '0, "R8", "flags cleared by start", errFlag, 0);
    if (disturb) begin
      repeat (10) @(posedge clk);
      #2;
      // R9: new configuration and start while busy must be ignored
      cfgAlgo = ~cfgAlgo; cfgTopIndex = 5; cfgInvert = ~cfgInvert; start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
    end
    @(negedge clk);
    while (!done) @(negedge clk);
    check(expQ.size() == 0, (top == 0) ? "R10" : "R8", "ops left at done", expQ.size(), 0);
    check(!busy, "R8", "busy with done", busy, 0);
    check(errFlag == expErr, "R7", "errFlag", errFlag, expErr);
    if (expErr) check(failAddr == expFail, "R7", "failAddr", failAddr, expFail);
    expQ.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check(!busy && !done && !errFlag, "R1", "flags in reset", {busy, done, errFlag}, 0);
    check(!memWe && !memRe && failAddr == '0, "R1", "strobes in reset", {memWe, memRe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !errFlag && !memWe && !memRe, "R1", "after reset release",
          {busy, done, errFlag, memWe, memRe}, 0);
    monOn = 1'b1;

    // R3 solid over full range, then hand checks of the map (R2)
    runTest(0, NW - 1, 1'b0, -1, '0, 1'b0, "R3");
    check(firstAddr == 7'd24, "R2", "device address of index 0", firstAddr, 24);
    check(lastAddr == 7'd120, "R2", "device address of index 127", lastAddr, 120);
    // R3 solid on 16 words: MSB low for first half, high for second
    runTest(0, 15, 1'b0, -1, '0, 1'b0, "R3");
    // R4 checkerboard, inverted, with a read fault
    runTest(1, 40, 1'b1, 17, 4'b0100, 1'b0, "R4");
    // R5 march full range with a fault; first failing read latched (R7)
    runTest(2, NW - 1, 1'b0, 90, 4'b0001, 1'b0, "R5");
    // R8/R9 clean solid after an error, disturbed mid-run
    runTest(0, NW - 1, 1'b1, -1, '0, 1'b1, "R9");
    // R5 code 3 behaves as march, inverted background
    runTest(3, 20, 1'b1, -1, '0, 1'b0, "R5");
    // R10 single word march with fault
    runTest(2, 0, 1'b0, 0, 4'b1000, 1'b0, "R10");
    // R9 disturb during march
    runTest(2, 30, 1'b0, 12, 4'b0010, 1'b1, "R9");

    repeat (3) @(negedge clk);
    check(done && !busy, "R8", "done held without start", done, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule